// File: doc/BRIEF.md
# Two-Wire EEPROM Slave Protocol Engine

This block is the bus-facing front end of a small serial EEPROM on a two-wire bus. It samples the clock and data lines with a faster system clock and finds start and stop conditions. It shifts bytes in and out most significant bit first and checks the device address. It drives acknowledges and read data through an active-high pull-down enable for the open-drain data line.

It handles byte and page writes, address-only (dummy) writes followed by a repeated start, current-address reads and sequential reads. The word-address counter and the write buffer sit outside the block. They are driven through single-cycle strobes: load the address, increment it, push a data byte, and start the internal rewrite. While the rewrite is running, the surrounding logic holds `busy_i` high. The block then answers no device address, so a master can poll for completion.

A parameter selects the large-array variant. In that variant the lowest select bit of the device byte is not compared with the strap inputs. It becomes the most significant bit of the 9-bit word address instead.

Top module: `eeprom_bus_slave`

## Requirements
- R1: A start condition (data falling while the clock is high) seen in any state abandons the current frame and begins reception of a device-address byte. The abandoned frame produces no strobe.
- R2: The device byte is matched when bits 7:4 equal 1010 and the select bits match `strap_i`. The select bits are bits 3:1 in the default variant, or bits 3:2 against `strap_i[2:1]` in the large variant. Bit 0 selects read (1) or write (0). On a match while not busy, the data line is pulled low for the whole ninth clock of that byte.
- R3: A device byte that does not match gets no acknowledge. Every later byte gets no acknowledge and produces no strobe until the next start condition.
- R4: While `busy_i` is high, a device byte is not acknowledged, even if it matches.
- R5: The word-address byte of a write frame is acknowledged and produces one `addr_load_o` pulse. `addr_val_o` then carries the byte, and in the large variant it also carries bit 1 of the device byte as address bit 8.
- R6: Each data byte of a write frame is acknowledged. It produces one `wr_o` pulse carrying the byte on `wr_data_o`, together with one `addr_inc_o` pulse.
- R7: A stop condition (data rising while the clock is high) after at least one write data byte produces a single-cycle `commit_o`. A frame that carries only a word address and then ends by a stop or a repeated start produces no commit and no `wr_o`.
- R8: In a read, the byte on `rd_data_i` is sent most significant bit first, each bit changing only while the clock is low. `addr_inc_o` pulses once after the falling clock edge of the eighth bit, and the line is released for the ninth clock.
- R9: When the master pulls the line low on the ninth clock of a read byte, the next byte is sent from the advanced address. When the master leaves it high, the block releases the line and sends nothing until the next start condition.
- R10: After reset the pull-down is off and no strobe is active. The pull-down changes only while the sampled clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| strap_i | input | 3 | Board-strapped select value |
| busy_i | input | 1 | Internal rewrite in progress |
| rd_data_i | input | 8 | Byte stored at the current word address |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| addr_load_o | output | 1 | Load the word-address counter |
| addr_val_o | output | 8 (9 in large variant) | Word address to load |
| addr_inc_o | output | 1 | Advance the word-address counter |
| wr_o | output | 1 | Push a byte into the write buffer |
| wr_data_o | output | 8 | Byte to push |
| commit_o | output | 1 | Start the internal rewrite |

## Verification
A wrong frame state shows up first at the ninth clock of the byte where it goes wrong. An acknowledge can appear for a foreign or busy address, or go missing for a valid one. The scoreboard then sees a spurious or missing load, push, increment or commit strobe within one bus-clock period. A wrong bit counter or shift register corrupts the read byte, and the bench catches this bit by bit in that same byte. A bad end-of-read decision shows as a driven line on the clock that follows the master's missing acknowledge.

// File: rtl/tws_pkg.sv
// Shared constants and the frame state type of the two-wire slave.
// Assumes byte-wide transfers with one acknowledge slot per byte.
package tws_pkg;
    localparam logic [3:0] DEV_CODE = 4'b1010;
    localparam int         BYTE_W   = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_WADDR,
        ST_WDATA,
        ST_RDATA
    } tws_state_e;
endpackage

// File: rtl/tws_line_sync.sv
// Brings the bus clock and data lines into the system clock domain and
// derives clock edges plus start and stop events from the sampled levels.
// Assumes the system clock is several times faster than the bus clock.
module tws_line_sync #(
    parameter int SYNC_DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    // stage SYNC_DEPTH-1 is the synchronized level, stage SYNC_DEPTH the one before
    logic [SYNC_DEPTH:0] scl_sh;
    logic [SYNC_DEPTH:0] sda_sh;
    logic scl_prev;
    logic sda_prev;

    // Shift both lines through the synchronizer; idle bus level is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
        end else begin
            scl_sh <= {scl_sh[SYNC_DEPTH-1:0], scl_i};
            sda_sh <= {sda_sh[SYNC_DEPTH-1:0], sda_i};
        end
    end

    assign scl_o    = scl_sh[SYNC_DEPTH-1];
    assign sda_o    = sda_sh[SYNC_DEPTH-1];
    assign scl_prev = scl_sh[SYNC_DEPTH];
    assign sda_prev = sda_sh[SYNC_DEPTH];

    // Event decode: data edges only count while the clock stays high.
    assign scl_rise_o = scl_o & ~scl_prev;
    assign scl_fall_o = ~scl_o & scl_prev;
    assign start_o    = scl_o & scl_prev & sda_prev & ~sda_o;
    assign stop_o     = scl_o & scl_prev & ~sda_prev & sda_o;
endmodule

// File: rtl/tws_addr_match.sv
// Decodes a received device byte: fixed code, select bits, direction,
// and in the large variant the address-extension bit.
// Assumes straps are static while frames are in flight.
module tws_addr_match
    import tws_pkg::*;
#(
    parameter int LARGE_ARRAY = 0
) (
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [2:0]        strap_i,
    output logic              hit_o,
    output logic              read_o,
    output logic              page_o
);
    logic sel_ok;

    generate
        if (LARGE_ARRAY != 0) begin : g_large
            // lowest select bit extends the word address instead of selecting
            logic unused_strap0;
            assign unused_strap0 = strap_i[0];
            assign sel_ok = (byte_i[3:2] == strap_i[2:1]);
            assign page_o = byte_i[1];
        end else begin : g_small
            assign sel_ok = (byte_i[3:1] == strap_i);
            assign page_o = 1'b0;
        end
    endgenerate

    assign hit_o  = (byte_i[7:4] == DEV_CODE) && sel_ok;
    assign read_o = byte_i[0];
endmodule

// File: rtl/tws_proto_fsm.sv
// Frame sequencer: counts bits, shifts data, decides acknowledges and
// issues address, write-buffer and commit strobes.
// Assumes sampled bus events arrive as single-cycle pulses.
module tws_proto_fsm
    import tws_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              sda_i,
    input  logic              hit_i,
    input  logic              rd_req_i,
    input  logic              page_i,
    input  logic              busy_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic [BYTE_W-1:0] rx_byte_o,
    output logic              pull_o,
    output logic              load_o,
    output logic [AW-1:0]     load_val_o,
    output logic              inc_o,
    output logic              wr_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              commit_o
);
    localparam int            CW       = $clog2(BYTE_W + 2);
    localparam logic [CW-1:0] ACK_SLOT = CW'(BYTE_W);
    localparam logic [CW-1:0] END_SLOT = CW'(BYTE_W + 1);

    tws_state_e          state_q, after_q;
    logic [CW-1:0]       cnt_q;
    logic [BYTE_W-1:0]   rx_q;
    logic [BYTE_W-2:0]   tx_q;
    logic                mack_q, page_q, got_q, pull_q;
    logic                load_q, wr_q, inc_q, commit_q;

    // Frame sequencing, bit shifting, acknowledge and strobe generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            after_q  <= ST_IDLE;
            cnt_q    <= '0;
            rx_q     <= '0;
            tx_q     <= '0;
            mack_q   <= 1'b1;
            page_q   <= 1'b0;
            got_q    <= 1'b0;
            pull_q   <= 1'b0;
            load_q   <= 1'b0;
            wr_q     <= 1'b0;
            inc_q    <= 1'b0;
            commit_q <= 1'b0;
        end else begin
            load_q   <= 1'b0;
            wr_q     <= 1'b0;
            inc_q    <= 1'b0;
            commit_q <= 1'b0;
            if (start_i) begin
                state_q <= ST_DEV;
                cnt_q   <= '0;
                pull_q  <= 1'b0;
                got_q   <= 1'b0;
            end else if (stop_i) begin
                commit_q <= (state_q == ST_WDATA) && got_q;
                state_q  <= ST_IDLE;
                pull_q   <= 1'b0;
                got_q    <= 1'b0;
            end else if (state_q != ST_IDLE) begin
                if (scl_rise_i) begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q < ACK_SLOT)
                        rx_q <= {rx_q[BYTE_W-2:0], sda_i};
                    else if (cnt_q == ACK_SLOT)
                        mack_q <= sda_i;
                end else if (scl_fall_i) begin
                    if (cnt_q == ACK_SLOT) begin
                        case (state_q)
                            ST_DEV: begin
                                if (hit_i && !busy_i) begin
                                    pull_q  <= 1'b1;
                                    page_q  <= page_i;
                                    after_q <= rd_req_i ? ST_RDATA : ST_WADDR;
                                end else begin
                                    state_q <= ST_IDLE;
                                end
                            end
                            ST_WADDR: begin
                                pull_q  <= 1'b1;
                                load_q  <= 1'b1;
                                after_q <= ST_WDATA;
                            end
                            ST_WDATA: begin
                                pull_q  <= 1'b1;
                                wr_q    <= 1'b1;
                                inc_q   <= 1'b1;
                                got_q   <= 1'b1;
                                after_q <= ST_WDATA;
                            end
                            ST_RDATA: begin
                                pull_q <= 1'b0;
                                inc_q  <= 1'b1;
                            end
                            default: state_q <= ST_IDLE;
                        endcase
                    end else if (cnt_q == END_SLOT) begin
                        cnt_q  <= '0;
                        pull_q <= 1'b0;
                        if (state_q == ST_RDATA) begin
                            if (!mack_q) begin
                                tx_q   <= rd_data_i[BYTE_W-2:0];
                                pull_q <= ~rd_data_i[BYTE_W-1];
                            end else begin
                                state_q <= ST_IDLE;
                            end
                        end else begin
                            state_q <= after_q;
                            if (after_q == ST_RDATA) begin
                                tx_q   <= rd_data_i[BYTE_W-2:0];
                                pull_q <= ~rd_data_i[BYTE_W-1];
                            end
                        end
                    end else if (state_q == ST_RDATA && cnt_q != '0) begin
                        tx_q   <= {tx_q[BYTE_W-3:0], 1'b0};
                        pull_q <= ~tx_q[BYTE_W-2];
                    end
                end
            end
        end
    end

    assign rx_byte_o  = rx_q;
    assign pull_o     = pull_q;
    assign load_o     = load_q;
    assign load_val_o = AW'({page_q, rx_q});
    assign inc_o      = inc_q;
    assign wr_o       = wr_q;
    assign wr_data_o  = rx_q;
    assign commit_o   = commit_q;
endmodule

// File: rtl/eeprom_bus_slave.sv
// Top of the two-wire EEPROM slave front end: line synchronizer,
// device-address decoder and frame sequencer.
// Assumes an external word-address counter and write buffer follow the strobes.
module eeprom_bus_slave
    import tws_pkg::*;
#(
    parameter int  LARGE_ARRAY = 0,
    parameter int  SYNC_DEPTH  = 2,
    localparam int AW          = 8 + ((LARGE_ARRAY != 0) ? 1 : 0)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [2:0]        strap_i,
    input  logic              busy_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic              sda_pull_o,
    output logic              addr_load_o,
    output logic [AW-1:0]     addr_val_o,
    output logic              addr_inc_o,
    output logic              wr_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              commit_o
);
    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic hit, rd_req, page_bit;
    logic [BYTE_W-1:0] rx_byte;

    tws_line_sync #(.SYNC_DEPTH(SYNC_DEPTH)) sync_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_o(scl_lvl), .sda_o(sda_lvl), .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall), .start_o(start_det), .stop_o(stop_det)
    );

    tws_addr_match #(.LARGE_ARRAY(LARGE_ARRAY)) match_i (
        .byte_i(rx_byte), .strap_i(strap_i), .hit_o(hit),
        .read_o(rd_req), .page_o(page_bit)
    );

    tws_proto_fsm #(.AW(AW)) fsm_i (
        .clk(clk), .rst_n(rst_n), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
        .start_i(start_det), .stop_i(stop_det), .sda_i(sda_lvl), .hit_i(hit),
        .rd_req_i(rd_req), .page_i(page_bit), .busy_i(busy_i),
        .rd_data_i(rd_data_i), .rx_byte_o(rx_byte), .pull_o(sda_pull_o),
        .load_o(addr_load_o), .load_val_o(addr_val_o), .inc_o(addr_inc_o),
        .wr_o(wr_o), .wr_data_o(wr_data_o), .commit_o(commit_o)
    );
endmodule

// File: rtl/tws_checker.sv
// Protocol properties of the slave front end, bound to every instance.
// Assumes the same synchronous active-low reset as the design.
module tws_checker (
    input logic clk,
    input logic rst_n,
    input logic scl_lvl,
    input logic stop_det,
    input logic busy_i,
    input logic sda_pull_o,
    input logic addr_load_o,
    input logic wr_o,
    input logic commit_o
);
    AST_PULL_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lvl && $past(scl_lvl)) |-> $stable(sda_pull_o)); // R10

    AST_ACK_STARTS_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> !scl_lvl); // R2

    AST_COMMIT_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> $past(stop_det)); // R7

    AST_COMMIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> !commit_o); // R7

    AST_BUSY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |-> !(addr_load_o || wr_o)); // R4

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({addr_load_o, wr_o, commit_o}) <= 1); // R5
endmodule

bind eeprom_bus_slave tws_checker chk_i (
    .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .stop_det(stop_det),
    .busy_i(busy_i), .sda_pull_o(sda_pull_o), .addr_load_o(addr_load_o),
    .wr_o(wr_o), .commit_o(commit_o)
);

// File: tb/eeprom_bus_slave_tb_top.sv
// Scoreboard bench: a bus-master driver pushes the strobes it expects,
// a monitor pops and compares them as both devices raise them.
module eeprom_bus_slave_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 6;
    localparam int BUSY_CYC   = 400;
    localparam int WD_CYC     = 150000;
    localparam logic [2:0] K_LOAD = 3'd1, K_WR = 3'd2, K_INC = 3'd3, K_COMMIT = 3'd4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_pull = 1'b0;
    logic sda_bus;
    int   checks = 0;
    int   errors = 0;
    bit   finished = 1'b0;
    logic [15:0] exp_q[$];

    logic pull_a, load_a, inc_a, wr_a, commit_a, busy_a;
    logic pull_b, load_b, inc_b, wr_b, commit_b, busy_b;
    logic [7:0] val_a, wdata_a, wdata_b, rdata_a, rdata_b;
    logic [8:0] val_b;
    logic [7:0] mem_a [256];
    logic [7:0] mem_b [512];
    logic [7:0] ptr_a;
    logic [8:0] ptr_b;
    int busy_cnt_a, busy_cnt_b;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sda_bus = ~(m_pull | pull_a | pull_b);

    eeprom_bus_slave dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .strap_i(3'b101),
        .busy_i(busy_a), .rd_data_i(rdata_a), .sda_pull_o(pull_a),
        .addr_load_o(load_a), .addr_val_o(val_a), .addr_inc_o(inc_a),
        .wr_o(wr_a), .wr_data_o(wdata_a), .commit_o(commit_a)
    );

    eeprom_bus_slave #(.LARGE_ARRAY(1)) dut_big (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .strap_i(3'b011),
        .busy_i(busy_b), .rd_data_i(rdata_b), .sda_pull_o(pull_b),
        .addr_load_o(load_b), .addr_val_o(val_b), .addr_inc_o(inc_b),
        .wr_o(wr_b), .wr_data_o(wdata_b), .commit_o(commit_b)
    );

    function automatic logic [7:0] seed(input int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    // Environment: word-address counters, storage and rewrite timers.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 512; i++) begin
                mem_b[i] <= seed(i) ^ 8'hA5;
                if (i < 256) mem_a[i] <= seed(i);
            end
            ptr_a <= '0; ptr_b <= '0; busy_cnt_a <= 0; busy_cnt_b <= 0;
        end else begin
            if (load_a) ptr_a <= val_a; else if (inc_a) ptr_a <= ptr_a + 8'd1;
            if (load_b) ptr_b <= val_b; else if (inc_b) ptr_b <= ptr_b + 9'd1;
            if (wr_a) mem_a[ptr_a] <= wdata_a;
            if (wr_b) mem_b[ptr_b] <= wdata_b;
            busy_cnt_a <= commit_a ? BUSY_CYC : (busy_cnt_a > 0 ? busy_cnt_a - 1 : 0);
            busy_cnt_b <= commit_b ? BUSY_CYC : (busy_cnt_b > 0 ? busy_cnt_b - 1 : 0);
        end
    end
    assign busy_a  = (busy_cnt_a != 0);
    assign busy_b  = (busy_cnt_b != 0);
    assign rdata_a = mem_a[ptr_a];
    assign rdata_b = mem_b[ptr_b];

    function automatic logic [15:0] item(input bit dev, input logic [2:0] k, input int v);
        return {dev, k, 12'(v)};
    endfunction

    function automatic string tag_of(input logic [2:0] k);
        case (k)
            K_LOAD:  return "R5 address load";
            K_WR:    return "R6 data push";
            K_INC:   return "R8 address advance";
            default: return "R7 commit";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic expect_ev(input bit dev, input logic [2:0] k, input int v);
        exp_q.push_back(item(dev, k, v));
    endtask

    task automatic sb_take(input logic [15:0] got);
        logic [15:0] want;
        if (exp_q.size() == 0) begin
            check(1'b0, {"unexpected strobe ", tag_of(got[14:12])}, int'(got), 0);
        end else begin
            want = exp_q.pop_front();
            check(got == want, tag_of(want[14:12]), int'(got), int'(want));
        end
    endtask

    // Monitor: strobes are registered, so sample them between edges.
    always @(negedge clk) begin
        if (rst_n) begin
            if (load_a)   sb_take(item(1'b0, K_LOAD, int'(val_a)));
            if (wr_a)     sb_take(item(1'b0, K_WR, int'(wdata_a)));
            if (inc_a)    sb_take(item(1'b0, K_INC, 0));
            if (commit_a) sb_take(item(1'b0, K_COMMIT, 0));
            if (load_b)   sb_take(item(1'b1, K_LOAD, int'(val_b)));
            if (wr_b)     sb_take(item(1'b1, K_WR, int'(wdata_b)));
            if (inc_b)    sb_take(item(1'b1, K_INC, 0));
            if (commit_b) sb_take(item(1'b1, K_COMMIT, 0));
        end
    end

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bit_io(input logic b, output logic smp);
        wait_q(); m_pull = ~b;
        wait_q(); scl = 1'b1;
        wait_q(); smp = sda_bus;
        wait_q(); scl = 1'b0;
    endtask

    task automatic do_start();
        m_pull = 1'b0; wait_q();
        scl = 1'b1;    wait_q();
        m_pull = 1'b1; wait_q();
        scl = 1'b0;
    endtask

    task automatic do_stop();
        wait_q(); m_pull = 1'b1;
        wait_q(); scl = 1'b1;
        wait_q(); m_pull = 1'b0;
        wait_q();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_io(b[i], s);
        bit_io(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] d);
        logic s;
        for (int i = 0; i < 8; i++) begin
            bit_io(1'b1, s);
            d = {d[6:0], s};
        end
        bit_io(~give_ack, s);
    endtask

    task automatic send_chk(input logic [7:0] b, input bit exp_ack, input string tag);
        logic ack;
        send_byte(b, ack);
        check(ack == exp_ack, tag, int'(ack), int'(exp_ack));
    endtask

    task automatic read_chk(input bit dev, input bit give_ack, input logic [7:0] exp, input string tag);
        logic [7:0] d;
        expect_ev(dev, K_INC, 0);
        recv_byte(give_ack, d);
        check(d == exp, tag, int'(d), int'(exp));
    endtask

    initial begin
        logic s;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R10: reset leaves the line released and strobes idle
        check(pull_a == 1'b0 && pull_b == 1'b0, "R10 reset pull", int'({pull_a, pull_b}), 0);
        check(sda_bus == 1'b1, "R10 reset bus level", int'(sda_bus), 1);

        // Byte write to the default device (select 101)
        do_start();
        send_chk(8'hAA, 1'b1, "R2 device ack write");
        expect_ev(1'b0, K_LOAD, 'h35);
        send_chk(8'h35, 1'b1, "R5 word address ack");
        expect_ev(1'b0, K_WR, 'h5C); expect_ev(1'b0, K_INC, 0);
        send_chk(8'h5C, 1'b1, "R6 data ack");
        expect_ev(1'b0, K_COMMIT, 0);
        do_stop();

        // R4: polling while busy gets no acknowledge
        do_start();
        send_chk(8'hAB, 1'b0, "R4 busy poll");
        do_stop();
        repeat (BUSY_CYC + 20) @(negedge clk);

        // Current-address read at 0x36, master declines further bytes
        do_start();
        send_chk(8'hAB, 1'b1, "R2 device ack read");
        read_chk(1'b0, 1'b0, seed('h36), "R8 current read byte");
        bit_io(1'b1, s);
        check(s == 1'b1, "R9 released after no-ack", int'(s), 1);
        do_stop();

        // Dummy write then sequential read from 0x35 (R7: no commit expected)
        do_start();
        send_chk(8'hAA, 1'b1, "R2 dummy write device");
        expect_ev(1'b0, K_LOAD, 'h35);
        send_chk(8'h35, 1'b1, "R5 dummy address");
        do_start();
        send_chk(8'hAB, 1'b1, "R2 repeated start read");
        read_chk(1'b0, 1'b1, 8'h5C, "R8 written byte read back");
        read_chk(1'b0, 1'b1, seed('h36), "R9 next byte after master ack");
        read_chk(1'b0, 1'b0, seed('h37), "R9 third byte");
        do_stop();

        // Page write of three bytes at 0x40, then read back
        do_start();
        send_chk(8'hAA, 1'b1, "R2 page write device");
        expect_ev(1'b0, K_LOAD, 'h40);
        send_chk(8'h40, 1'b1, "R5 page address");
        for (int i = 1; i <= 3; i++) begin
            expect_ev(1'b0, K_WR, 'h11 * i); expect_ev(1'b0, K_INC, 0);
            send_chk(8'(8'h11 * i), 1'b1, "R6 page data ack");
        end
        expect_ev(1'b0, K_COMMIT, 0);
        do_stop();
        repeat (BUSY_CYC + 20) @(negedge clk);
        do_start();
        send_chk(8'hAA, 1'b1, "R2 readback device");
        expect_ev(1'b0, K_LOAD, 'h40);
        send_chk(8'h40, 1'b1, "R5 readback address");
        do_start();
        send_chk(8'hAB, 1'b1, "R2 readback read");
        read_chk(1'b0, 1'b1, 8'h11, "R6 page byte 0");
        read_chk(1'b0, 1'b1, 8'h22, "R6 page byte 1");
        read_chk(1'b0, 1'b0, 8'h33, "R6 page byte 2");
        do_stop();

        // R3: foreign select bits and foreign device code are ignored
        do_start();
        send_chk(8'hA2, 1'b0, "R3 select mismatch");
        send_chk(8'h12, 1'b0, "R3 byte after mismatch");
        send_chk(8'h34, 1'b0, "R3 second byte after mismatch");
        do_stop();
        do_start();
        send_chk(8'h2A, 1'b0, "R3 code mismatch");
        do_stop();

        // Large variant: select bit 0 becomes address bit 8
        do_start();
        send_chk(8'hA6, 1'b1, "R2 large device ack");
        expect_ev(1'b1, K_LOAD, 'h110);
        send_chk(8'h10, 1'b1, "R5 large address with extension bit");
        expect_ev(1'b1, K_WR, 'h77); expect_ev(1'b1, K_INC, 0);
        send_chk(8'h77, 1'b1, "R6 large data ack");
        expect_ev(1'b1, K_COMMIT, 0);
        do_stop();
        do_start();
        send_chk(8'hA7, 1'b0, "R4 large busy poll");
        do_stop();
        do_start();
        send_chk(8'hAB, 1'b1, "R4 other device unaffected");
        read_chk(1'b0, 1'b0, seed('h43), "R8 read at 0x43");
        do_stop();
        repeat (BUSY_CYC + 20) @(negedge clk);
        do_start();
        send_chk(8'hA6, 1'b1, "R2 large dummy write");
        expect_ev(1'b1, K_LOAD, 'h110);
        send_chk(8'h10, 1'b1, "R5 large reload");
        do_start();
        send_chk(8'hA7, 1'b1, "R2 large read");
        read_chk(1'b1, 1'b0, 8'h77, "R5 large byte read back");
        do_stop();
        do_start();
        send_chk(8'hA5, 1'b1, "R2 large read with other extension bit");
        read_chk(1'b1, 1'b0, seed('h111) ^ 8'hA5, "R8 large current read");
        do_stop();

        // R1: start in the middle of a word address abandons that frame
        do_start();
        send_chk(8'hAA, 1'b1, "R1 device before abort");
        for (int i = 0; i < 4; i++) bit_io(1'b1, s);
        do_start();
        send_chk(8'hAB, 1'b1, "R1 device after restart");
        read_chk(1'b0, 1'b0, seed('h44), "R1 address untouched by abort");
        do_stop();

        repeat (50) @(negedge clk);
        check(exp_q.size() == 0, "R7 missing strobes", exp_q.size(), 0);
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL R1 watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule